// File: doc/BRIEF.md
# Bit-Reversed Strided Vector Load Unit

This block runs the element loop of a vector load whose elements are visited in bit-reversed order, the access pattern that radix-2 FFT and DCT butterflies need. A single start pulse captures a load form, a base register value, a signed 16-bit displacement, a 5-bit shift amount and the base-two logarithm of the vector length. The block then walks the step index from 0 to VL-1, one element per clock. For each element it forms `EA = base + ((bitrev(step) * sext(disp)) << shift)` in 64-bit wrap-around arithmetic and issues a read on a synchronous memory port. Two cycles after the read, it presents the zero- or sign-extended result.

Update forms move the base along with the loop. Each effective address becomes the base for the next element, and it is also presented for write-back into the base register together with that element's result. Forms that are illegal are refused at start. No memory traffic follows, and the refusal is reported on a one-cycle flag.

Top module: `brev_load_unit`

## Requirements
- R1: For the displacement forms (op 0 to 3), element k reads from `EA = base + ((rev(k) * sext16(disp)) << shift)`, computed mod 2^64. In the non-update form, base is 0 when `ra_idx` is 0 and `ra_val` otherwise.
- R2: For ops 4 (word algebraic) and 5 (doubleword), the displacement is `sext({disp[13:0], 2'b00})`, so it is always a multiple of 4.
- R3: `rev(k)` reverses the low `vl_log2` bits of k, with VL = 2^`vl_log2` (0 to 6). When `vl_log2` is 0, the single element reads exactly at base.
- R4: After an accepted start, reads are issued on consecutive cycles starting the next cycle. Steps run 0, 1, …, VL-1, one per cycle, and exactly VL reads are issued.
- R5: The result of the read issued in cycle c appears with `res_valid` in cycle c+2, and `res_step` carries its step index.
- R6: Memory data is little-endian, with `mem_rd_data[7:0]` holding the byte at EA. Op 0 yields that byte, op 1 the low 16 bits and op 3 the low 32 bits, each with all upper bits cleared.
- R7: Op 2 sign-extends 16 bits and op 4 sign-extends 32 bits to 64. Op 5 returns all 64 bits.
- R8: In the update form (`update`=1), base starts at `ra_val`, and each element's EA becomes the base of the next element. `ra_wr_en` is high with every result, with `ra_wr_data` equal to that element's EA. In the non-update form, `ra_wr_en` stays low.
- R9: A start is refused if the op is 6 or 7, if `vl_log2` > 6, or if it is an update form with `ra_idx` = 0 or `ra_idx` = `rt_idx`. A refused start pulses `invalid` and `done` in the next cycle, with no reads and no results.
- R10: `done` pulses for one cycle, together with the last result of an accepted operation.
- R11: A start while `busy` is high is ignored: the running operation's addresses and results are unchanged, and no extra operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when not busy) |
| op | input | 3 | Load form: 0 byte, 1 half zero, 2 half sign, 3 word zero, 4 word sign, 5 doubleword |
| update | input | 1 | Update form: base follows EA and is written back |
| ra_idx | input | 5 | Base register number |
| rt_idx | input | 5 | Target register number |
| ra_val | input | 64 | Base register contents |
| disp | input | 16 | Signed displacement field |
| shamt | input | 5 | Left shift applied to the element offset |
| vl_log2 | input | 3 | log2 of the vector length |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (pulse) |
| invalid | output | 1 | Start refused as an illegal form (pulse) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 64 | Memory read address (EA) |
| mem_rd_data | input | 64 | Read data, valid the cycle after the strobe |
| res_valid | output | 1 | Result valid |
| res_step | output | 6 | Step index of the result |
| res_data | output | 64 | Extended load result |
| ra_wr_en | output | 1 | Base register write-back strobe |
| ra_wr_data | output | 64 | Base register write-back value |

## Verification
The bench sweeps every load form with both update settings and several vector lengths. It uses displacements with the top bit set, so that a missing sign extension or a dropped DS concatenation shifts every address. A bit-reversal that flips all six bits instead of the low `vl_log2` bits shows up as wrong addresses at small vector lengths, and the VL=1 case catches a nonzero offset for the lone element. Memory bytes often have their top bit set, so that zero and sign extension produce visibly different upper words. Update runs check the cumulative base chain, illegal forms check that no read leaks out, and a start pulsed mid-run checks that the loop is not restarted or corrupted.

// File: rtl/brev_pkg.sv
package brev_pkg;
    localparam int XLEN   = 64;
    localparam int DISP_W = 16;
    localparam int DS_W   = DISP_W - 2;
    localparam int SH_W   = 5;
    localparam int LG_W   = 3;
    localparam int MAX_LG = 6;
    localparam int STEP_W = MAX_LG;
    localparam int IDX_W  = 5;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_BZ = 3'd0,
        OP_HZ = 3'd1,
        OP_HA = 3'd2,
        OP_WZ = 3'd3,
        OP_WA = 3'd4,
        OP_DW = 3'd5
    } op_e;

    function automatic logic op_is_ds(input op_e k);
        return (k == OP_WA) || (k == OP_DW);
    endfunction
endpackage

// File: rtl/brev_seq.sv
module brev_seq
    import brev_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LG_W-1:0]   lg,
    output logic              issue,
    output logic              last,
    output logic [STEP_W-1:0] step
);
    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t s_d, s_q;
    logic [STEP_W-1:0] limit;

    always_comb begin
        limit = STEP_W'((32'd1 << lg) - 32'd1);
        issue = s_q.run;
        step  = s_q.step;
        last  = s_q.run && (s_q.step == limit);
        s_d   = s_q;
        if (s_q.run) begin
            if (last) begin
                s_d.run  = 1'b0;
                s_d.step = '0;
            end else begin
                s_d.step = s_q.step + 1'b1;
            end
        end else if (go) begin
            s_d.run  = 1'b1;
            s_d.step = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_FIRST_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(issue) |-> step == '0); // R4
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !last |=> issue && step == $past(step) + 1'b1); // R4
endmodule

// File: rtl/brev_addr_gen.sv
module brev_addr_gen
    import brev_pkg::*;
(
    input  logic [XLEN-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  logic              ds_form,
    input  logic [SH_W-1:0]   shamt,
    input  logic [LG_W-1:0]   lg,
    input  logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] rev,
    output logic [XLEN-1:0]   ea
);
    logic [DISP_W-1:0] dfield;
    logic [XLEN-1:0]   dext;
    logic [XLEN-1:0]   prod;
    logic [XLEN-1:0]   offs;

    always_comb begin
        rev = '0;
        for (int i = 0; i < STEP_W; i++) begin
            for (int j = 0; j < STEP_W; j++) begin
                if ((i < int'(lg)) && (j == int'(lg) - 1 - i)) rev[i] = step[j];
            end
        end
        dfield = ds_form ? {disp[DS_W-1:0], 2'b00} : disp;
        dext   = {{(XLEN-DISP_W){dfield[DISP_W-1]}}, dfield};
        prod   = dext * XLEN'(rev);
        offs   = prod << shamt;
        ea     = base + offs;
    end
endmodule

// File: rtl/brev_fmt.sv
module brev_fmt
    import brev_pkg::*;
(
    input  op_e             kind,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] data
);
    always_comb begin
        unique case (kind)
            OP_BZ:   data = {{(XLEN-8){1'b0}}, raw[7:0]};
            OP_HZ:   data = {{(XLEN-16){1'b0}}, raw[15:0]};
            OP_HA:   data = {{(XLEN-16){raw[15]}}, raw[15:0]};
            OP_WZ:   data = {{(XLEN-32){1'b0}}, raw[31:0]};
            OP_WA:   data = {{(XLEN-32){raw[31]}}, raw[31:0]};
            default: data = raw;
        endcase
    end
endmodule

// File: rtl/brev_load_unit.sv
module brev_load_unit
    import brev_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic              update,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rt_idx,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [SH_W-1:0]   shamt,
    input  logic [LG_W-1:0]   vl_log2,
    output logic              busy,
    output logic              done,
    output logic              invalid,
    output logic              mem_rd_en,
    output logic [XLEN-1:0]   mem_rd_addr,
    input  logic [XLEN-1:0]   mem_rd_data,
    output logic              res_valid,
    output logic [STEP_W-1:0] res_step,
    output logic [XLEN-1:0]   res_data,
    output logic              ra_wr_en,
    output logic [XLEN-1:0]   ra_wr_data
);
    typedef struct packed {
        op_e               cfg_kind;
        logic              cfg_upd;
        logic [DISP_W-1:0] cfg_disp;
        logic [SH_W-1:0]   cfg_sh;
        logic [LG_W-1:0]   cfg_lg;
        logic [XLEN-1:0]   base;
        logic              p1_vld;
        logic              p1_last;
        logic [STEP_W-1:0] p1_step;
        logic [XLEN-1:0]   p1_ea;
        logic              o_vld;
        logic [STEP_W-1:0] o_step;
        logic [XLEN-1:0]   o_data;
        logic              o_wr;
        logic [XLEN-1:0]   o_wr_data;
        logic              o_done;
        logic              o_inv;
    } st_t;

    st_t d, q;

    logic              issue, last, bad, accept, go;
    logic [STEP_W-1:0] step, rev;
    logic [XLEN-1:0]   ea, fmt_data;

    brev_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .lg    (q.cfg_lg),
        .issue (issue),
        .last  (last),
        .step  (step)
    );

    brev_addr_gen u_addr (
        .base    (q.base),
        .disp    (q.cfg_disp),
        .ds_form (op_is_ds(q.cfg_kind)),
        .shamt   (q.cfg_sh),
        .lg      (q.cfg_lg),
        .step    (step),
        .rev     (rev),
        .ea      (ea)
    );

    brev_fmt u_fmt (
        .kind (q.cfg_kind),
        .raw  (mem_rd_data),
        .data (fmt_data)
    );

    always_comb begin
        busy   = issue | q.p1_vld;
        bad    = (op > OP_W'(OP_DW)) || (vl_log2 > LG_W'(MAX_LG)) ||
                 (update && ((ra_idx == '0) || (ra_idx == rt_idx)));
        accept = start && !busy;
        go     = accept && !bad;

        d = q;
        if (go) begin
            d.cfg_kind = op_e'(op);
            d.cfg_upd  = update;
            d.cfg_disp = disp;
            d.cfg_sh   = shamt;
            d.cfg_lg   = vl_log2;
            d.base     = (!update && ra_idx == '0) ? '0 : ra_val;
        end
        if (issue && q.cfg_upd) d.base = ea;

        d.p1_vld  = issue;
        d.p1_last = last;
        d.p1_step = step;
        d.p1_ea   = ea;

        d.o_vld     = q.p1_vld;
        d.o_step    = q.p1_step;
        d.o_data    = q.p1_vld ? fmt_data : '0;
        d.o_wr      = q.p1_vld && q.cfg_upd;
        d.o_wr_data = q.p1_ea;
        d.o_done    = (q.p1_vld && q.p1_last) || (accept && bad);
        d.o_inv     = accept && bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.cfg_kind <= OP_BZ;
        end else begin
            q <= d;
        end
    end

    assign mem_rd_en   = issue;
    assign mem_rd_addr = ea;
    assign done        = q.o_done;
    assign invalid     = q.o_inv;
    assign res_valid   = q.o_vld;
    assign res_step    = q.o_step;
    assign res_data    = q.o_data;
    assign ra_wr_en    = q.o_wr;
    assign ra_wr_data  = q.o_wr_data;

    AST_REFUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && bad |=> invalid && done && !mem_rd_en); // R9
    AST_READ_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 res_valid); // R5
    AST_WB_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ra_wr_en |-> res_valid && ra_wr_data == $past(mem_rd_addr, 2)); // R8
    AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && q.cfg_kind == OP_BZ |-> res_data[XLEN-1:8] == '0); // R6
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_valid || invalid); // R10
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_en); // R4
endmodule

// File: tb/sim_brev_load_unit.sv
module sim_brev_load_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic        update = 1'b0;
    logic [4:0]  ra_idx = '0;
    logic [4:0]  rt_idx = '0;
    logic [63:0] ra_val = '0;
    logic [15:0] disp = '0;
    logic [4:0]  shamt = '0;
    logic [2:0]  vl_log2 = '0;
    logic        busy, done, invalid, mem_rd_en, res_valid, ra_wr_en;
    logic [63:0] mem_rd_addr, res_data, ra_wr_data;
    logic [63:0] mem_rd_data = '0;
    logic [5:0]  res_step;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    brev_load_unit u0 (.*);

    function automatic logic [7:0] mbyte(input logic [63:0] a);
        return a[7:0] ^ {a[3:0], a[7:4]} ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [63:0] mword(input logic [63:0] a);
        logic [63:0] w;
        for (int i = 0; i < 8; i++) w[8*i +: 8] = mbyte(a + 64'(i));
        return w;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mword(mem_rd_addr);

    function automatic logic [5:0] brev(input int k, input int lg);
        logic [5:0] r = '0;
        for (int i = 0; i < lg; i++) r[i] = k[lg-1-i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input int o, input bit upd, input int rai, input int rti,
                       input logic [63:0] rav, input logic [15:0] dv, input int sh,
                       input int lg, input bit poke);
        logic [63:0] exp_ea[64];
        logic [63:0] exp_d[64];
        int          rd_cyc[64];
        logic [63:0] cur, dx, m;
        bit          refuse;
        int          vl, nr, nres, ndone, ninv;
        refuse = (o > 5) || (lg > 6) || (upd && (rai == 0 || rai == rti));
        vl = refuse ? 0 : (1 << lg);
        dx = (o == 4 || o == 5) ? {{50{dv[13]}}, dv[13:0], 2'b00} : {{48{dv[15]}}, dv};
        cur = (!upd && rai == 0) ? 64'd0 : rav;
        for (int k = 0; k < vl; k++) begin
            exp_ea[k] = cur + ((dx * 64'(brev(k, lg))) << sh);
            if (upd) cur = exp_ea[k];
            m = mword(exp_ea[k]);
            case (o)
                0: exp_d[k] = {56'd0, m[7:0]};
                1: exp_d[k] = {48'd0, m[15:0]};
                2: exp_d[k] = {{48{m[15]}}, m[15:0]};
                3: exp_d[k] = {32'd0, m[31:0]};
                4: exp_d[k] = {{32{m[31]}}, m[31:0]};
                default: exp_d[k] = m;
            endcase
        end
        @(negedge clk);
        op = 3'(o); update = upd; ra_idx = 5'(rai); rt_idx = 5'(rti);
        ra_val = rav; disp = dv; shamt = 5'(sh); vl_log2 = 3'(lg); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nr = 0; nres = 0; ndone = 0; ninv = 0;
        for (int c = 0; c < vl + 6; c++) begin
            if (poke && c < 2) begin
                start = 1'b1; op = 3'd1; update = 1'b0; ra_idx = 5'd0;
                disp = 16'h0101; shamt = 5'd1; vl_log2 = 3'd1;
            end else begin
                start = 1'b0;
            end
            if (mem_rd_en) begin
                if (nr < vl) begin
                    chk(mem_rd_addr == exp_ea[nr],
                        (lg == 0) ? "R3" : ((o == 4 || o == 5) ? "R2" : "R1"),
                        mem_rd_addr, exp_ea[nr]);
                    rd_cyc[nr] = c;
                end
                nr++;
            end
            if (res_valid) begin
                if (nres < vl) begin
                    chk(res_step == 6'(nres), "R4", 64'(res_step), 64'(nres));
                    chk(c == rd_cyc[nres] + 2, "R5", 64'(c), 64'(rd_cyc[nres] + 2));
                    chk(res_data == exp_d[nres], (o == 0 || o == 1 || o == 3) ? "R6" : "R7",
                        res_data, exp_d[nres]);
                    chk(ra_wr_en == upd, "R8", 64'(ra_wr_en), 64'(upd));
                    if (upd) chk(ra_wr_data == exp_ea[nres], "R8", ra_wr_data, exp_ea[nres]);
                end
                nres++;
            end
            if (done) begin
                ndone++;
                if (!refuse) chk(res_valid && nres == vl, "R10", 64'(nres), 64'(vl));
            end
            if (invalid) ninv++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(nr == vl, refuse ? "R9" : (poke ? "R11" : "R4"), 64'(nr), 64'(vl));
        chk(nres == vl, refuse ? "R9" : (poke ? "R11" : "R5"), 64'(nres), 64'(vl));
        chk(ndone == 1, "R10", 64'(ndone), 64'd1);
        chk(ninv == (refuse ? 1 : 0), "R9", 64'(ninv), 64'(refuse));
        chk(!busy, "R10", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lgs[4] = '{0, 2, 4, 6};
        repeat (3) @(negedge clk);
        chk(!busy && !done && !invalid && !mem_rd_en && !res_valid && !ra_wr_en,
            "R4", {58'd0, busy, done, invalid, mem_rd_en, res_valid, ra_wr_en}, 64'd0);
        rst_n = 1'b1;
        for (int o = 0; o < 6; o++) begin
            for (int u = 0; u < 2; u++) begin
                for (int li = 0; li < 4; li++) begin
                    run(o, u[0], (u == 0 && li[0]) ? 0 : 3, 4,
                        64'h0000_1234_5678_9000 + 64'(o * 97 + li),
                        16'h8000 ^ 16'(o * 16'h1357 + li * 16'h0421),
                        (o * 7 + li * 5) % 32, lgs[li], 1'b0);
                end
            end
        end
        run(5, 1'b0, 0, 2, 64'hFFFF_FFFF_FFFF_FFF0, 16'h7FFF, 0, 3, 1'b0);
        run(4, 1'b1, 6, 7, 64'h8000_0000_0000_0000, 16'hFFFF, 31, 5, 1'b0);
        run(2, 1'b1, 0, 5, 64'h1000, 16'h0010, 0, 2, 1'b0);
        run(3, 1'b1, 9, 9, 64'h1000, 16'h0010, 0, 2, 1'b0);
        run(6, 1'b0, 1, 2, 64'h1000, 16'h0010, 0, 2, 1'b0);
        run(7, 1'b0, 1, 2, 64'h1000, 16'h0010, 0, 2, 1'b0);
        run(1, 1'b0, 1, 2, 64'h1000, 16'h0010, 0, 7, 1'b0);
        run(0, 1'b0, 3, 2, 64'h2000, 16'hFFF3, 2, 3, 1'b1);
        run(5, 1'b1, 3, 2, 64'h4000, 16'h0123, 1, 0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule